// File: doc/BRIEF.md
# Harvard Accumulator Core with Memory-Resident Program Counter

This block is a small 8-bit accumulator processor. Instructions are read from their own program store, and operands live in a separate 32-word data store. The two stores have separate address spaces and separate access paths. There is no dedicated program-counter register. The address of the next instruction is held in an ordinary data word, so a program jumps to an absolute address by storing a value into that word.

Each instruction takes six clock cycles, taken in a fixed order of phases. Both stores are loaded from constant images when reset is applied. One data address acts as the external port. Reading it returns the value on the input pins, and storing to it updates the registered output pins. A halt instruction freezes the core until the next reset.

Top module: `acc8_core`

## Requirements
- R1: An instruction is 8 bits. Bits [7:5] hold the opcode and bits [4:0] hold a data address. The opcodes are 000 load, 001 store, 010 add, 011 subtract, 100 and, 101 halt. Codes 110 and 111 are reserved.
- R2: Every instruction takes exactly six clock cycles, in this order: fetch, decode, operand read, compute, write, advance. After reset the core begins in the fetch phase.
- R3: Load copies the operand into the accumulator. Add computes acc+operand, subtract computes acc-operand, and and computes the bitwise AND, each modulo 256.
- R4: Store writes the accumulator to the addressed data word. No other opcode writes the data store.
- R5: A reserved opcode leaves the accumulator, the data store and the output pins unchanged, and the program address still advances by one.
- R6: The program address is data word 20. The fetch uses its low 5 bits. The advance phase adds 1 to this word, modulo 256.
- R7: A store to word 20 sets the address of the next fetch to the stored value, and the advance phase of that instruction does not increment it.
- R8: An operand read from word 20 returns the address of the instruction being executed.
- R9: Reading data address 31 returns `in_port`. A store to address 31 updates `out_port`, which otherwise holds its value.
- R10: Halt sets `halted` during its decode phase. After that no instruction executes and `halted` stays high until reset.
- R11: Synchronous reset clears the accumulator, word 20, `out_port` and `halted`, and reloads both stores from their images.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_port | input | 8 | Value returned by reads of data address 31 |
| out_port | output | 8 | Last value stored to data address 31 |
| halted | output | 1 | Sticky flag set by the halt instruction |

## Verification
Two updates can target word 20 within one instruction: a store to that word during the write phase, and the automatic increment during the advance phase. The test program stores a jump target into word 20 and places a marker store at the target. If the increment were not suppressed, execution would land one word later, the marker would be skipped, and the output sequence and halt cycle would differ. The same program also loads word 20 as an operand to show that the read returns the current instruction's address. A cycle-level reference model is compared with the pins on every clock.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

    localparam int WORD_W   = 8;
    localparam int AWIDTH   = 5;
    localparam int NWORDS   = 1 << AWIDTH;
    localparam int IMG_BITS = NWORDS * WORD_W;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_ADD   = 3'd2,
        OP_SUB   = 3'd3,
        OP_AND   = 3'd4,
        OP_HALT  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        PH_FETCH   = 3'd0,
        PH_DECODE  = 3'd1,
        PH_OPERAND = 3'd2,
        PH_EXEC    = 3'd3,
        PH_WRITE   = 3'd4,
        PH_ADVANCE = 3'd5
    } phase_e;

    typedef enum logic [2:0] {
        ALU_NONE = 3'd0,
        ALU_PASS = 3'd1,
        ALU_ADD  = 3'd2,
        ALU_SUB  = 3'd3,
        ALU_AND  = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic    fetch_en;
        logic    halt_req;
        logic    rd_en;
        logic    acc_en;
        logic    wr_en;
        logic    inc_en;
        alu_op_e alu_op;
    } ctrl_t;

    function automatic logic uses_operand(opcode_e op);
        return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND);
    endfunction

    // Echo loop: copy the input port to the output port forever.
    function automatic logic [IMG_BITS-1:0] default_prog_image();
        logic [IMG_BITS-1:0] img;
        img = '0;
        img[0*WORD_W +: WORD_W] = {OP_LOAD,  5'd31};
        img[1*WORD_W +: WORD_W] = {OP_STORE, 5'd31};
        img[2*WORD_W +: WORD_W] = {OP_LOAD,  5'd5};
        img[3*WORD_W +: WORD_W] = {OP_STORE, 5'd20};
        return img;
    endfunction

endpackage

// File: rtl/acc8_sequencer.sv
module acc8_sequencer
    import acc8_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   halt_req,
    output phase_e phase,
    output logic   halted
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_FETCH;
            halted <= 1'b0;
        end else if (!halted) begin
            if (halt_req)
                halted <= 1'b1;
            else if (phase == PH_ADVANCE)
                phase <= PH_FETCH;
            else
                phase <= phase_e'(phase + 3'd1);
        end
    end

    assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ADVANCE && !halted) |=> (phase == PH_FETCH));

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(phase));
endmodule

// File: rtl/acc8_decoder.sv
module acc8_decoder
    import acc8_pkg::*;
(
    input  phase_e  phase,
    input  opcode_e op,
    output ctrl_t   ctrl
);
    always_comb begin
        ctrl          = '0;
        ctrl.alu_op   = ALU_NONE;
        ctrl.fetch_en = (phase == PH_FETCH);
        ctrl.halt_req = (phase == PH_DECODE) && (op == OP_HALT);
        ctrl.rd_en    = (phase == PH_OPERAND) && uses_operand(op);
        ctrl.acc_en   = (phase == PH_EXEC) && uses_operand(op);
        ctrl.wr_en    = (phase == PH_WRITE) && (op == OP_STORE);
        ctrl.inc_en   = (phase == PH_ADVANCE);
        if (phase == PH_EXEC) begin
            case (op)
                OP_LOAD: ctrl.alu_op = ALU_PASS;
                OP_ADD:  ctrl.alu_op = ALU_ADD;
                OP_SUB:  ctrl.alu_op = ALU_SUB;
                OP_AND:  ctrl.alu_op = ALU_AND;
                default: ctrl.alu_op = ALU_NONE;
            endcase
        end
    end
endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
    import acc8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] result
);
    always_comb begin
        case (op)
            ALU_PASS: result = opnd;
            ALU_ADD:  result = acc + opnd;
            ALU_SUB:  result = acc - opnd;
            ALU_AND:  result = acc & opnd;
            default:  result = acc;
        endcase
    end
endmodule

// File: rtl/acc8_datamem.sv
module acc8_datamem #(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 5,
    parameter int PC_ADDR = 20,
    parameter int IO_ADDR = 31,
    parameter logic [(1<<ADDR_W)*DATA_W-1:0] INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inc_en,
    input  logic [DATA_W-1:0] in_port,
    output logic [DATA_W-1:0] out_port,
    output logic [DATA_W-1:0] pc_word
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] PC_A = ADDR_W'(PC_ADDR);
    localparam logic [ADDR_W-1:0] IO_A = ADDR_W'(IO_ADDR);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              pc_stored;

    assign rd_data = (addr == IO_A) ? in_port : mem[addr];
    assign pc_word = mem[PC_A];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= (i == PC_ADDR) ? '0 : INIT[i*DATA_W +: DATA_W];
            out_port  <= '0;
            pc_stored <= 1'b0;
        end else begin
            if (wr_en) begin
                mem[addr] <= wr_data;
                if (addr == PC_A) pc_stored <= 1'b1;
                if (addr == IO_A) out_port  <= wr_data;
            end
            if (inc_en) begin
                if (!pc_stored) mem[PC_A] <= mem[PC_A] + 1'b1;
                pc_stored <= 1'b0;
            end
        end
    end

    assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == IO_A) |=> $stable(out_port));

    assert_jump_load_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == PC_A) |=> (pc_word == $past(wr_data)));

    assert_jump_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (inc_en && pc_stored) |=> $stable(pc_word));
endmodule

// File: rtl/acc8_core.sv
module acc8_core
    import acc8_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 5,
    parameter int PC_ADDR = 20,
    parameter int IO_ADDR = 31,
    parameter logic [(1<<ADDR_W)*DATA_W-1:0] PROG_IMG = default_prog_image(),
    parameter logic [(1<<ADDR_W)*DATA_W-1:0] DATA_IMG = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_port,
    output logic [DATA_W-1:0] out_port,
    output logic              halted
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int OPC_W = DATA_W - ADDR_W;
    localparam logic [ADDR_W-1:0] PC_A = ADDR_W'(PC_ADDR);

    logic [DATA_W-1:0] prog [DEPTH];
    logic [DATA_W-1:0] ir, acc, opnd, alu_y, rd_data, pc_word;
    phase_e            phase;
    ctrl_t             ctrl;
    opcode_e           op;
    logic [ADDR_W-1:0] op_addr;

    assign op      = opcode_e'(ir[DATA_W-1 -: OPC_W]);
    assign op_addr = ir[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                prog[i] <= PROG_IMG[i*DATA_W +: DATA_W];
            ir   <= '0;
            acc  <= '0;
            opnd <= '0;
        end else begin
            if (ctrl.fetch_en) ir   <= prog[pc_word[ADDR_W-1:0]];
            if (ctrl.rd_en)    opnd <= rd_data;
            if (ctrl.acc_en)   acc  <= alu_y;
        end
    end

    acc8_sequencer u_seq (
        .clk(clk), .rst(rst), .halt_req(ctrl.halt_req),
        .phase(phase), .halted(halted)
    );

    acc8_decoder u_dec (.phase(phase), .op(op), .ctrl(ctrl));

    acc8_alu #(.DATA_W(DATA_W)) u_alu (
        .op(ctrl.alu_op), .acc(acc), .opnd(opnd), .result(alu_y)
    );

    acc8_datamem #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PC_ADDR(PC_ADDR),
        .IO_ADDR(IO_ADDR), .INIT(DATA_IMG)
    ) u_dmem (
        .clk(clk), .rst(rst), .addr(op_addr), .rd_data(rd_data),
        .wr_en(ctrl.wr_en), .wr_data(acc), .inc_en(ctrl.inc_en),
        .in_port(in_port), .out_port(out_port), .pc_word(pc_word)
    );

    assert_pc_step_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ADVANCE && !(op == OP_STORE && op_addr == PC_A))
        |=> (pc_word == $past(pc_word) + 1'b1));

    assert_acc_only_exec_R4: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_EXEC) |=> $stable(acc));
endmodule

// File: tb/test_acc8_core.sv
module test_acc8_core;

    function automatic logic [255:0] tb_prog();
        logic [255:0] p;
        p = '0;
        p[0*8  +: 8] = 8'h1F;  // load 31 (input)
        p[1*8  +: 8] = 8'h4A;  // add 10
        p[2*8  +: 8] = 8'h3F;  // store 31
        p[3*8  +: 8] = 8'h6B;  // sub 11
        p[4*8  +: 8] = 8'h3F;
        p[5*8  +: 8] = 8'h8C;  // and 12
        p[6*8  +: 8] = 8'h3F;
        p[7*8  +: 8] = 8'hC0;  // reserved 110
        p[8*8  +: 8] = 8'h14;  // load 20 (pc)
        p[9*8  +: 8] = 8'h3F;
        p[10*8 +: 8] = 8'h0D;  // load 13 (target 16)
        p[11*8 +: 8] = 8'h34;  // store 20 -> jump
        p[12*8 +: 8] = 8'h3F;  // skipped
        p[16*8 +: 8] = 8'h3F;  // marker store
        p[17*8 +: 8] = 8'hE0;  // reserved 111
        p[18*8 +: 8] = 8'hA0;  // halt
        return p;
    endfunction

    function automatic logic [255:0] tb_data();
        logic [255:0] d;
        d = '0;
        d[10*8 +: 8] = 8'h0F;
        d[11*8 +: 8] = 8'h3C;
        d[12*8 +: 8] = 8'h05;
        d[13*8 +: 8] = 8'h10;
        return d;
    endfunction

    localparam logic [255:0] P_IMG = tb_prog();
    localparam logic [255:0] D_IMG = tb_data();

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_port = 8'h00;
    logic [7:0] out_port;
    logic       halted;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    acc8_core #(.PROG_IMG(P_IMG), .DATA_IMG(D_IMG)) i_acc8_core (
        .clk(clk), .rst(rst), .in_port(in_port),
        .out_port(out_port), .halted(halted)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, stepped once per clock.
    logic [7:0] m_mem [32];
    logic [7:0] m_ir, m_opnd, m_acc, m_out;
    int         m_ph;
    bit         m_halt, m_jmp;

    always @(posedge clk) begin
        int op, a;
        cyc++;
        if (rst) begin
            for (int i = 0; i < 32; i++) m_mem[i] = D_IMG[i*8 +: 8];
            m_mem[20] = 8'h00;
            m_ir = 0; m_opnd = 0; m_acc = 0; m_out = 0;
            m_ph = 0; m_halt = 0; m_jmp = 0;
        end else if (!m_halt) begin
            op = int'(m_ir[7:5]);
            a  = int'(m_ir[4:0]);
            case (m_ph)
                0: m_ir = P_IMG[int'(m_mem[20][4:0])*8 +: 8];
                1: if (op == 5) m_halt = 1;
                2: if (op == 0 || op == 2 || op == 3 || op == 4)
                       m_opnd = (a == 31) ? in_port : m_mem[a];
                3: case (op)
                       0: m_acc = m_opnd;
                       2: m_acc = m_acc + m_opnd;
                       3: m_acc = m_acc - m_opnd;
                       4: m_acc = m_acc & m_opnd;
                       default: ;
                   endcase
                4: if (op == 1) begin
                       m_mem[a] = m_acc;
                       if (a == 20) m_jmp = 1;
                       if (a == 31) m_out = m_acc;
                   end
                default: begin
                    if (!m_jmp) m_mem[20] = m_mem[20] + 8'd1;
                    m_jmp = 0;
                end
            endcase
            if (!m_halt) m_ph = (m_ph == 5) ? 0 : m_ph + 1;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(out_port == m_out, "R9 out_port vs model", out_port, m_out);
            check(halted == m_halt, "R10 halted vs model", halted, m_halt);
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(out_port == 8'h00, "R11 out_port after reset", out_port, 0);
        check(halted == 1'b0, "R11 halted after reset", halted, 0);
    endtask

    task automatic run_program(input logic [7:0] inval);
        logic [7:0] seen [$];
        logic [7:0] prev;
        logic [7:0] exp [5];
        int n;
        in_port = inval;
        apply_reset();
        prev = 8'h00;
        n = 0;
        while (!halted && n < 400) begin
            @(negedge clk);
            n++;
            if (out_port != prev) begin
                seen.push_back(out_port);
                prev = out_port;
            end
        end
        // R2 / R5: 14 instructions before halt, halt raised on its decode edge.
        check(n == 86, "R2 R5 cycles until halted", n, 86);
        exp[0] = inval + 8'h0F;          // R3 add with wrap
        exp[1] = exp[0] - 8'h3C;         // R3 sub with wrap
        exp[2] = exp[1] & 8'h05;         // R3 and
        exp[3] = 8'h08;                  // R8 pc read as operand
        exp[4] = 8'h10;                  // R7 jump target marker
        check(seen.size() == 5, "R4 R9 number of output updates", seen.size(), 5);
        for (int i = 0; i < 5; i++) begin
            if (i < seen.size())
                check(seen[i] == exp[i], (i < 3) ? "R3 R1 result" : (i == 3 ? "R8 pc operand" : "R7 R6 jump"),
                      seen[i], exp[i]);
        end
        repeat (20) @(negedge clk);
        check(halted == 1'b1, "R10 halted sticky", halted, 1);
        check(out_port == 8'h10, "R10 no execution after halt", out_port, 8'h10);
    endtask

    initial begin
        run_program(8'h20);
        run_program(8'hF5);
        // Reset in mid-run.
        in_port = 8'h7E;
        apply_reset();
        repeat (30) @(negedge clk);
        check(out_port != 8'h00, "R9 output written mid-run", out_port, 1);
        apply_reset();
        run_program(8'h00);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule